// File: doc/BRIEF.md
# Dual-Precision Output-Stationary Multiply-Accumulate Grid

This block is a square grid of multiply-accumulate cells that computes one tile of a matrix product in place. Every cycle, one beat arrives: a column of signed 8-bit activations, one per grid row, and a row of weight bytes, one per grid column. Internally, each activation moves one cell to the right per cycle and each weight byte moves one cell down per cycle. Cells talk only to their direct neighbours through registers. The results never move until the pass is over: every cell keeps its own 32-bit accumulator.

The grid has two arithmetic modes. In the wide mode, a weight byte is one signed 8-bit value and each cell accumulates a 32-bit sum of 16-bit products. In the split mode, each weight byte carries two signed 4-bit weights, and each cell forms two products per cycle. Those two products go into two independent saturating 16-bit sums, packed into the same 32-bit register. The split mode therefore doubles the number of products per beat without widening any operand path or result register.

A pass works as follows:
- A `clr` pulse zeroes the grid and latches the mode and the beat count.
- The caller streams that many beats over a valid/ready input.
- After the skew has flushed, `done` rises.
- The result rows are offered one per cycle over a valid/ready output.

Input back-pressure rules:
- `in_ready` is high only while the pass still wants beats.
- A beat is taken on any cycle where `in_valid` and `in_ready` are both high.
- Idle input cycles contribute nothing.

Output back-pressure rules:
- A row is held, index and data unchanged, for as long as `out_ready` is low.

Top module: `dwsa_array`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `in_ready`, `out_valid` and `done` are 0.
- R2: A `clr` pulse zeroes every accumulator and latches `mode_in` and `k_len`. If `k_len` is nonzero, `in_ready` is 1 in the cycle after the pulse.
- R3: `in_ready` stays high until exactly `k_len` beats have been taken (`in_valid && in_ready` at a clock edge). Cycles with `in_valid` low add nothing to any result. `in_ready` and `out_valid` are never high together.
- R4: In wide mode (mode 0), cell (r,c) ends with the 32-bit wrap-around sum over all beats of signed act[r] times signed wgt[c]. Here act[r] is `act_vec[8r+7:8r]` and wgt[c] is `wgt_vec[8c+7:8c]`.
- R5: In split mode (mode 1), wgt bits [3:0] form a signed 4-bit weight whose products go into result bits [15:0]. Bits [7:4] form a signed 4-bit weight whose products go into result bits [31:16]. No carry passes between the two halves.
- R6: In split mode, a 16-bit sum that would exceed 32767 or fall below -32768 clamps to that limit. A half holding exactly 32767 or -32768 keeps that value for the rest of the pass.
- R7: `done` rises exactly 2N-2 clock edges after the edge that takes the final beat. It stays high until the last result row has been taken.
- R8: While `done` is high, `out_valid` is high and rows are offered in order 0 to N-1 on `out_row_idx`. Cell (r,c) appears at `out_row[32c+31:32c]`. A row is held while `out_ready` is low. After row N-1 is taken, `done` and `out_valid` fall.
- R9: Changes of `mode_in` between `clr` pulses have no effect on the running pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start pulse: zero the grid, latch mode and beat count |
| mode_in | input | 1 | 0 = wide 8x8 mode, 1 = split dual 8x4 mode |
| k_len | input | KW | Number of beats in the pass |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Grid accepts a beat |
| act_vec | input | 8N | One signed activation per grid row |
| wgt_vec | input | 8N | One weight byte per grid column |
| done | output | 1 | Pass complete, results draining |
| out_valid | output | 1 | Result row valid |
| out_ready | input | 1 | Consumer takes the result row |
| out_row_idx | output | max(1,log2 N) | Index of the row on `out_row` |
| out_row | output | 32N | Accumulators of one grid row |

## Verification
The bench builds a 4x4 grid with a 6-bit beat count. That count allows passes of up to 63 beats, which is enough to drive split-mode halves past both 16-bit limits and to confirm that they stay pinned there. It also lets wide-mode sums of extreme operands grow well beyond 16 bits. The 4x4 size puts the full 6-cycle skew flush and the four-row drain, with stalls on both streams, inside a short run.

// File: rtl/dwsa_pkg.sv
package dwsa_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FEED  = 2'd1,
    PH_FLUSH = 2'd2,
    PH_DRAIN = 2'd3
  } phase_t;

  // Saturating 16-bit add of a signed 12-bit product; a half at a limit stays there.
  function automatic logic [15:0] half_sat_add(input logic [15:0] cur, input logic [11:0] prod);
    logic [16:0] s;
    if (cur == 16'h7FFF || cur == 16'h8000) return cur;
    s = {cur[15], cur} + {{5{prod[11]}}, prod};
    if (s[16] != s[15]) return s[16] ? 16'h8000 : 16'h7FFF;
    return s[15:0];
  endfunction

endpackage

// File: rtl/dwsa_pe.sv
module dwsa_pe
  import dwsa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        mixed,
  input  logic [7:0]  a_in,
  input  logic [7:0]  w_in,
  output logic [7:0]  a_out,
  output logic [7:0]  w_out,
  output logic [31:0] acc
);
  logic [15:0] p_wide;
  logic [11:0] p_lo, p_hi;
  logic [31:0] acc_nxt;

  always_comb begin
    p_wide = {{8{a_in[7]}}, a_in} * {{8{w_in[7]}}, w_in};
    p_lo   = {{4{a_in[7]}}, a_in} * {{8{w_in[3]}}, w_in[3:0]};
    p_hi   = {{4{a_in[7]}}, a_in} * {{8{w_in[7]}}, w_in[7:4]};
    if (mixed) acc_nxt = {half_sat_add(acc[31:16], p_hi), half_sat_add(acc[15:0], p_lo)};
    else       acc_nxt = acc + {{16{p_wide[15]}}, p_wide};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out <= '0;
      w_out <= '0;
      acc   <= '0;
    end else if (clr) begin
      a_out <= '0;
      w_out <= '0;
      acc   <= '0;
    end else begin
      a_out <= a_in;
      w_out <= w_in;
      acc   <= acc_nxt;
    end
  end
endmodule

// File: rtl/dwsa_skew.sv
module dwsa_skew #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [N*8-1:0] in_vec,
  output logic [N*8-1:0] out_vec
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    if (i == 0) begin : g_pass
      assign out_vec[7:0] = in_vec[7:0];
    end else begin : g_dly
      logic [7:0] sr [i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < i; j++) sr[j] <= '0;
        end else if (clr) begin
          for (int j = 0; j < i; j++) sr[j] <= '0;
        end else begin
          sr[0] <= in_vec[i*8 +: 8];
          for (int j = 1; j < i; j++) sr[j] <= sr[j-1];
        end
      end
      assign out_vec[i*8 +: 8] = sr[i-1];
    end
  end
endmodule

// File: rtl/dwsa_ctrl.sv
module dwsa_ctrl
  import dwsa_pkg::*;
#(
  parameter int N  = 4,
  parameter int KW = 8,
  localparam int FL  = 2*N - 2,
  localparam int FLW = (FL > 1) ? $clog2(FL) : 1,
  localparam int RW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mode_in,
  input  logic [KW-1:0] k_len,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          mixed,
  output logic          done,
  output logic          out_valid,
  output logic [RW-1:0] row_idx
);
  phase_t        phase;
  logic [KW-1:0] klen_q, fed;
  logic [KW-1:0] fed_nx;
  logic [FLW-1:0] fl_cnt;
  phase_t        after_feed;

  assign fed_nx     = fed + 1'b1;
  assign after_feed = (FL == 0) ? PH_DRAIN : PH_FLUSH;
  assign in_ready   = (phase == PH_FEED);
  assign out_valid  = (phase == PH_DRAIN);
  assign done       = out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      klen_q  <= '0;
      fed     <= '0;
      fl_cnt  <= '0;
      mixed   <= 1'b0;
      row_idx <= '0;
    end else if (clr) begin
      phase   <= (k_len == '0) ? after_feed : PH_FEED;
      klen_q  <= k_len;
      fed     <= '0;
      fl_cnt  <= '0;
      mixed   <= mode_in;
      row_idx <= '0;
    end else begin
      case (phase)
        PH_FEED: if (in_valid) begin
          fed <= fed_nx;
          if (fed_nx == klen_q) phase <= after_feed;
        end
        PH_FLUSH: begin
          fl_cnt <= fl_cnt + 1'b1;
          if (fl_cnt == FLW'(FL - 1)) phase <= PH_DRAIN;
        end
        PH_DRAIN: if (out_ready) begin
          row_idx <= row_idx + 1'b1;
          if (row_idx == RW'(N - 1)) phase <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dwsa_array.sv
module dwsa_array
  import dwsa_pkg::*;
#(
  parameter int N  = 4,
  parameter int KW = 8,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            mode_in,
  input  logic [KW-1:0]   k_len,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*8-1:0]  act_vec,
  input  logic [N*8-1:0]  wgt_vec,
  output logic            done,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [RW-1:0]   out_row_idx,
  output logic [N*32-1:0] out_row
);
  logic             fire, mixed_q;
  logic [N*8-1:0]   act_g, wgt_g, act_sk, wgt_sk;
  logic [7:0]       a_h [N][N+1];
  logic [7:0]       w_v [N+1][N];
  logic [31:0]      acc_m [N][N];
  logic [N*N*32-1:0] acc_flat;
  logic [2*N-1:0]   unused_edges;

  assign fire  = in_valid && in_ready;
  assign act_g = fire ? act_vec : '0;
  assign wgt_g = fire ? wgt_vec : '0;

  dwsa_ctrl #(.N(N), .KW(KW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_in(mode_in), .k_len(k_len),
    .in_valid(in_valid), .out_ready(out_ready), .in_ready(in_ready),
    .mixed(mixed_q), .done(done), .out_valid(out_valid), .row_idx(out_row_idx)
  );

  dwsa_skew #(.N(N)) u_skew_a (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vec(act_g), .out_vec(act_sk)
  );
  dwsa_skew #(.N(N)) u_skew_w (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vec(wgt_g), .out_vec(wgt_sk)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    assign a_h[r][0]       = act_sk[r*8 +: 8];
    assign w_v[0][r]       = wgt_sk[r*8 +: 8];
    assign unused_edges[r]   = ^a_h[r][N];
    assign unused_edges[N+r] = ^w_v[N][r];
    for (genvar c = 0; c < N; c++) begin : g_col
      dwsa_pe u_pe (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mixed(mixed_q),
        .a_in(a_h[r][c]), .w_in(w_v[r][c]),
        .a_out(a_h[r][c+1]), .w_out(w_v[r+1][c]),
        .acc(acc_m[r][c])
      );
      assign acc_flat[(r*N+c)*32 +: 32] = acc_m[r][c];
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) out_row[c*32 +: 32] = acc_m[out_row_idx][c];
  end
endmodule

module dwsa_array_chk #(
  parameter int N  = 4,
  localparam int RW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [RW-1:0]   out_row_idx,
  input logic [N*32-1:0] out_row,
  input logic            mixed_q,
  input logic [N*N*32-1:0] acc_flat
);
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_flat == '0));

  p_stream_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_sticky_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mixed_q && !clr && acc_flat[15:0] == 16'h7FFF) |=> (acc_flat[15:0] == 16'h7FFF));

  p_sticky_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mixed_q && !clr && acc_flat[31:16] == 16'h8000) |=> (acc_flat[31:16] == 16'h8000));

  p_drain_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_row_idx == '0));

  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_row_idx) && $stable(out_row)));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(mixed_q));
endmodule

bind dwsa_array dwsa_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_row_idx(out_row_idx), .out_row(out_row),
  .mixed_q(mixed_q), .acc_flat(acc_flat)
);

// File: tb/tb_dwsa_array.sv
`timescale 1ns/1ps
module tb_dwsa_array;
  localparam int N  = 4;
  localparam int KW = 6;
  localparam int RW = 2;

  logic clk = 0, rst_n = 0, clr = 0, mode_in = 0, in_valid = 0, out_ready = 1;
  logic [KW-1:0] k_len = '0;
  logic [N*8-1:0] act_vec = '0, wgt_vec = '0;
  logic in_ready, done, out_valid;
  logic [RW-1:0] out_row_idx;
  logic [N*32-1:0] out_row;

  always #4 clk = ~clk;

  dwsa_array #(.N(N), .KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_in(mode_in), .k_len(k_len),
    .in_valid(in_valid), .in_ready(in_ready), .act_vec(act_vec), .wgt_vec(wgt_vec),
    .done(done), .out_valid(out_valid), .out_ready(out_ready),
    .out_row_idx(out_row_idx), .out_row(out_row)
  );

  int checks = 0, fails = 0;
  logic signed [7:0] am [64][N];
  logic [7:0]        wm [64][N];
  logic [N*32-1:0]   exp_q [$];
  int                exp_idx = 0;
  string             cur_tag = "";
  logic              stall_out = 0;
  int                cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int sat16(input int cur, input int p);
    int s;
    if (cur == 32767 || cur == -32768) return cur;
    s = cur + p;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic push_expect(input bit mx, input int k);
    for (int r = 0; r < N; r++) begin
      logic [N*32-1:0] row;
      for (int c = 0; c < N; c++) begin
        int s = 0, lo = 0, hi = 0;
        for (int i = 0; i < k; i++) begin
          logic signed [7:0] wb;
          logic signed [3:0] nl, nh;
          wb = wm[i][c];
          nl = wm[i][c][3:0];
          nh = wm[i][c][7:4];
          s  += int'(am[i][r]) * int'(wb);
          lo = sat16(lo, int'(am[i][r]) * int'(nl));
          hi = sat16(hi, int'(am[i][r]) * int'(nh));
        end
        row[c*32 +: 32] = mx ? {hi[15:0], lo[15:0]} : s;
      end
      exp_q.push_back(row);
    end
  endtask

  // Scoreboard monitor: pops an expected row on every accepted output row.
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, {cur_tag, " unexpected row"}, out_row_idx, 0);
      else begin
        logic [N*32-1:0] e;
        e = exp_q.pop_front();
        check(out_row_idx == RW'(exp_idx), "R8 row order", out_row_idx, exp_idx);
        for (int c = 0; c < N; c++)
          check(out_row[c*32 +: 32] == e[c*32 +: 32], cur_tag, out_row[c*32 +: 32], e[c*32 +: 32]);
        exp_idx = (exp_idx + 1) % N;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    out_ready = stall_out ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic fill(input int pat, input int k);
    for (int i = 0; i < k; i++)
      for (int j = 0; j < N; j++) begin
        case (pat)
          1: begin am[i][j] = 8'(127 - j); wm[i][j] = 8'h77; end
          2: begin
            if (i < 38) begin am[i][j] = 8'(127 - j); wm[i][j] = 8'h87; end
            else        begin am[i][j] = 8'h80;       wm[i][j] = 8'h81; end
          end
          3: begin am[i][j] = 8'h80; wm[i][j] = 8'h80; end
          default: begin am[i][j] = 8'($urandom); wm[i][j] = 8'($urandom); end
        endcase
      end
  endtask

  task automatic run(input bit mx, input int k, input bit gaps, input bit flip, input int pat, input string tag);
    int i = 0;
    fill(pat, k);
    cur_tag = tag;
    exp_idx = 0;
    push_expect(mx, k);
    @(negedge clk);
    clr = 1; mode_in = mx; k_len = KW'(k);
    @(negedge clk);
    clr = 0;
    if (flip) mode_in = ~mx;
    #1 check(in_ready == 1'b1, "R2 in_ready after clr", in_ready, 1);
    while (i < k) begin
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
        act_vec[j*8 +: 8] = am[i][j];
        wgt_vec[j*8 +: 8] = wm[i][j];
      end
      in_valid = !(gaps && ($urandom_range(0, 2) == 0));
      #1;
      if (in_valid && in_ready) i++;
      @(posedge clk);
    end
    for (int j = 0; j <= 2*N-2; j++) begin
      @(negedge clk);
      if (j == 0) begin in_valid = 0; act_vec = '1; wgt_vec = '1; end
      #1;
      if (j == 0) check(in_ready == 1'b0, "R3 in_ready low after k beats", in_ready, 0);
      if (j == 2*N-3) check(done == 1'b0, "R7 done not early", done, 0);
      if (j == 2*N-2) check(done == 1'b1, "R7 done on time", done, 1);
    end
    while (done) @(negedge clk);
    #3;
    check(exp_q.size() == 0, "R8 all rows drained", exp_q.size(), 0);
    check(out_valid == 1'b0, "R8 out_valid low after drain", out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 0 && out_valid == 0 && done == 0, "R1 reset outputs", {in_ready, out_valid, done}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(in_ready == 0 && out_valid == 0 && done == 0, "R1 after reset", {in_ready, out_valid, done}, 0);
    run(0, 8, 0, 0, 0, "R4 wide random");
    stall_out = 1;
    run(1, 8, 1, 0, 0, "R5 split random gaps");
    run(1, 40, 0, 0, 1, "R6 split saturate");
    run(1, 45, 1, 0, 2, "R6 split sticky");
    stall_out = 0;
    run(0, 40, 1, 0, 3, "R4 wide extreme");
    run(0, 5, 1, 1, 0, "R9 mode flip wide");
    run(1, 1, 0, 1, 0, "R9 mode flip split");
    run(0, 63, 0, 0, 0, "R3 max beats");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule